// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescaler

The block is a watchdog timer for a system-on-chip. It holds an up-counter that software must rewrite before it rolls over. If the counter wraps from its all-ones value to zero, the block asks the chip's reset logic for a reset and sets a sticky status flag. Software can read that flag after the restart to tell a watchdog restart from a power-on restart.

The counter advances on a count enable. A four-bit clock-select field in the mode register picks where that enable comes from. When the top bit of the field is 1, the enable comes from one tap of a free-running system-clock prescaler, or from the undivided system clock. When the top bit is 0, the enable comes from rising edges of a slow oscillator tick input, which is synchronised first.

Software reaches three registers over a simple synchronous bus: the status register, the counter and the mode register. The status flag cannot be set by software. It can only be cleared, and only by a write that carries an unlock bit set to 1 and a write-inhibit bit cleared to 0.

Top module: `wdog_timer`

## Requirements
- R1: While `rst_n` is low, and after it is released, the counter reads 0x00, the status flag reads 0, the mode register reads 0xFF and `wdt_rst_req` is 0.
- R2: A write to address 1 loads the counter. A read of address 1 returns the current counter value. A read of address 3 returns 0.
- R3: For clock-select codes 1000 to 1110, the count enable is a single system-clock pulse once every 64, 128, 256, 512, 1024, 2048 or 8192 cycles respectively. Code 1111 makes the enable high on every cycle. The pulse comes in the cycle in which a 13-bit prescaler, which counts system clocks from 0 from reset, has all the low bits of the selected tap equal to one.
- R4: With a clock-select code whose bit 3 is 0, the counter advances once for each rising transition of `osc_tick`. The step lands on the third system-clock edge after the input is first sampled high.
- R5: A count enable with the counter at 0xFF makes the counter continue at 0x00. It also sets the status flag and raises `wdt_rst_req` for exactly one cycle. Both are visible in the cycle after that edge.
- R6: A counter write in the same cycle as a count enable wins. The counter takes the written value, and no wrap occurs.
- R7: Address 2 holds the mode register. Bits 3:0 are the clock-select field, which any write to address 2 can change. Bits 7:4 always read as 1.
- R8: The status register is at address 0, with the flag in bit 0, the write-inhibit bit in bit 1 and the unlock bit in bit 2. A write whose bits [2:0] are 100 clears the flag. Every other write value leaves the flag unchanged. A wrap in the same cycle as a clear sets the flag.
- R9: Software cannot set the flag by any write. Only a wrap sets it, and `rst_n` clears it. A read of address 0 returns the flag in bit 0 and 0 in all other bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low external reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| osc_tick | input | 1 | Slow oscillator tick, asynchronous to `clk` |
| wdt_rst_req | output | 1 | One-cycle internal reset request on counter wrap |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, prescaler taps from 2^6 up to a 13-bit prescaler, and a two-flop synchroniser. With these values, a wrap at the undivided clock takes only 256 cycles. The slowest tap, divide by 8192, can still be checked within the cycle budget by preloading the counter with 0xFF and watching it step. Every prescaler period, oscillator edge timing and wrap can therefore be compared cycle by cycle against a reference model in the bench.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   // Register addresses (bus decode)
   localparam int unsigned ADDR_STAT = 0;
   localparam int unsigned ADDR_CNT  = 1;
   localparam int unsigned ADDR_MODE = 2;

   // Status register bit positions
   localparam int unsigned STAT_FLAG_BIT   = 0;
   localparam int unsigned STAT_INH_BIT    = 1;
   localparam int unsigned STAT_UNLOCK_BIT = 2;

   // log2 of the divide ratio for the tap chosen by clock-select code {1,k}.
   // 0 means the tap is undivided.
   function automatic int tap_log2(input int k, input int log_min, input int log_max);
      if (k < 6)
         return log_min + k;
      else if (k == 6)
         return log_max;
      else
         return 0;
   endfunction

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
   parameter int LOG_MIN = 6,
   parameter int LOG_MAX = 13
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] tap_sel,
   output logic       tap_pulse
);
   localparam int NTAP = 8;
   localparam logic [LOG_MAX-1:0] PRE_ONE = 1;

   initial begin
      assert (LOG_MIN >= 1 && LOG_MAX > LOG_MIN + 5)
         else $error("wdog_prescaler: tap range too narrow");
   end

   logic [LOG_MAX-1:0] pre_q;
   logic [NTAP-1:0]    hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + PRE_ONE;
   end

   generate
      for (genvar k = 0; k < NTAP; k++) begin : g_tap
         localparam int LG = wdog_pkg::tap_log2(k, LOG_MIN, LOG_MAX);
         if (LG == 0) begin : g_full
            assign hit[k] = 1'b1;
         end else begin : g_div
            assign hit[k] = &pre_q[LG-1:0];
         end
      end
   endgenerate

   assign tap_pulse = hit[tap_sel];

   // R3: a divided tap never pulses in two cycles in a row
   p_tap_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tap_pulse && tap_sel != 3'd7) |=> !(tap_pulse && tap_sel != 3'd7));

endmodule

// File: rtl/wdog_tick_sync.sv
module wdog_tick_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_in,
   output logic tick
);
   initial begin
      assert (STAGES >= 2) else $error("wdog_tick_sync: need at least two stages");
   end

   // q[0..STAGES-1] synchronise; q[STAGES] holds the previous value for edge detection
   logic [STAGES:0] q;

   generate
      for (genvar i = 0; i <= STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q[0] <= 1'b0;
               else        q[0] <= osc_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q[i] <= 1'b0;
               else        q[i] <= q[i-1];
            end
         end
      end
   endgenerate

   assign tick = q[STAGES-1] & ~q[STAGES];

   // R4: one enable per rising transition, never two cycles wide
   p_tick_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] CNT_ONE = 1;

   assign wrap = cnt_en && !load && (&cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (load)   cnt_q <= load_val;
      else if (cnt_en) cnt_q <= cnt_q + CNT_ONE;
   end

   // R6: a load wins over a count enable in the same cycle
   p_load_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == $past(load_val)));

   // R5: after a wrap the counter continues from zero
   p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt_q == '0));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
   parameter int CNT_W       = 8,
   parameter int ADDR_W      = 2,
   parameter int PRE_LOG_MIN = 6,
   parameter int PRE_LOG_MAX = 13,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   input  logic              osc_tick,
   output logic              wdt_rst_req
);
   import wdog_pkg::*;

   localparam int SEL_W = 4;

   initial begin
      assert (CNT_W >= SEL_W && ADDR_W >= 2)
         else $error("wdog_timer: counter or address too narrow");
   end

   logic [SEL_W-1:0] sel_q;
   logic             flag_q;
   logic             pre_pulse, osc_en, cnt_en, wrap;
   logic [CNT_W-1:0] cnt_q;
   logic             wr_stat, wr_cnt, wr_mode, clr_ok;

   assign wr_stat = bus_we && (bus_addr == ADDR_W'(ADDR_STAT));
   assign wr_cnt  = bus_we && (bus_addr == ADDR_W'(ADDR_CNT));
   assign wr_mode = bus_we && (bus_addr == ADDR_W'(ADDR_MODE));
   assign clr_ok  = wr_stat && bus_wdata[STAT_UNLOCK_BIT]
                    && !bus_wdata[STAT_INH_BIT] && !bus_wdata[STAT_FLAG_BIT];

   wdog_prescaler #(.LOG_MIN(PRE_LOG_MIN), .LOG_MAX(PRE_LOG_MAX)) u_pre (
      .clk(clk), .rst_n(rst_n), .tap_sel(sel_q[2:0]), .tap_pulse(pre_pulse));

   wdog_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .osc_in(osc_tick), .tick(osc_en));

   assign cnt_en = sel_q[SEL_W-1] ? pre_pulse : osc_en;

   wdog_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .load(wr_cnt),
      .load_val(bus_wdata), .cnt_q(cnt_q), .wrap(wrap));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q       <= '1;
         flag_q      <= 1'b0;
         wdt_rst_req <= 1'b0;
      end else begin
         wdt_rst_req <= wrap;
         if (wr_mode) sel_q <= bus_wdata[SEL_W-1:0];
         if (wrap)        flag_q <= 1'b1;
         else if (clr_ok) flag_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADDR_W'(ADDR_STAT): bus_rdata[STAT_FLAG_BIT] = flag_q;
         ADDR_W'(ADDR_CNT):  bus_rdata = cnt_q;
         ADDR_W'(ADDR_MODE): bus_rdata = {{(CNT_W-SEL_W){1'b1}}, sel_q};
         default:            bus_rdata = '0;
      endcase
   end

   // R5: a wrap raises the flag and the request in the next cycle
   p_wrap_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (flag_q && wdt_rst_req));

   // R5: the request is exactly one cycle wide
   p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst_req |=> !wdt_rst_req);

   // R9: the flag is sticky unless a status write occurs
   p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !wr_stat) |=> flag_q);

   // R9: software cannot raise the flag
   p_no_sw_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q && !wrap) |=> !flag_q);

   // R7: reserved mode bits read as ones
   p_mode_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(ADDR_MODE)) |-> (&bus_rdata[CNT_W-1:SEL_W]));

endmodule

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       osc_tick = 1'b0;
   logic       wdt_rst_req;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;
   string phase = "";

   always #2.5 clk = ~clk;

   wdog_timer u_wdog_timer (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .osc_tick(osc_tick),
      .wdt_rst_req(wdt_rst_req));

   // Reference model built from the requirements
   logic [12:0] m_pre;
   logic [7:0]  m_cnt;
   logic [3:0]  m_sel;
   logic        m_flag, m_req, m_s1, m_s2, m_s3;

   function automatic int period(input logic [2:0] k);
      if (k < 3'd6)       return 1 << (6 + k);
      else if (k == 3'd6) return 8192;
      else                return 1;
   endfunction

   function automatic logic [7:0] exp_rd(input logic [1:0] a);
      case (a)
         2'd0:    return {7'd0, m_flag};
         2'd1:    return m_cnt;
         2'd2:    return {4'hF, m_sel};
         default: return 8'd0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pre = '0; m_cnt = '0; m_sel = 4'hF; m_flag = 0; m_req = 0;
         m_s1 = 0; m_s2 = 0; m_s3 = 0;
      end else begin
         logic en, wrapped;
         int p;
         p = period(m_sel[2:0]);
         if (m_sel[3]) en = (p == 1) || ((int'(m_pre) % p) == p - 1);
         else          en = m_s2 && !m_s3;
         wrapped = 0;
         if (bus_we && bus_addr == 2'd1) m_cnt = bus_wdata;
         else if (en) begin
            if (m_cnt == 8'hFF) wrapped = 1;
            m_cnt = m_cnt + 8'd1;
         end
         if (wrapped) m_flag = 1;
         else if (bus_we && bus_addr == 2'd0 && bus_wdata[2:0] == 3'b100) m_flag = 0;
         if (bus_we && bus_addr == 2'd2) m_sel = bus_wdata[3:0];
         m_req = wrapped;
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = osc_tick;
         m_pre = m_pre + 13'd1;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // One cycle: compare at the falling edge, then drive the next inputs
   task automatic cyc(input logic [1:0] a, input logic we, input logic [7:0] d, input logic osc);
      string tag;
      @(negedge clk);
      if (phase != "") tag = phase;
      else tag = (a == 2'd0) ? "R8" : (a == 2'd1) ? "R3" : (a == 2'd2) ? "R7" : "R2";
      chk(tag, bus_rdata, exp_rd(bus_addr));
      chk("R5", wdt_rst_req, m_req);
      bus_addr = a; bus_we = we; bus_wdata = d; osc_tick = osc;
   endtask

   task automatic idle(input logic [1:0] a, input int n);
      for (int i = 0; i < n; i++) cyc(a, 1'b0, 8'd0, osc_tick);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5EED_0001));
      // R1: reset values while reset is held
      repeat (3) @(negedge clk);
      bus_addr = 2'd1; #1 chk("R1", bus_rdata, 8'h00);
      bus_addr = 2'd2; #1 chk("R1", bus_rdata, 8'hFF);
      bus_addr = 2'd0; #1 chk("R1", bus_rdata, 8'h00);
      chk("R1", wdt_rst_req, 0);
      rst_n = 1'b1;
      phase = "R1";
      idle(2'd2, 2);

      // R2: load, read back, empty address
      phase = "R2";
      cyc(2'd2, 1'b1, 8'h0E, 1'b0);   // slowest tap so loaded value is stable
      cyc(2'd1, 1'b1, 8'h5A, 1'b0);
      idle(2'd1, 3);
      idle(2'd3, 2);

      // R6: writes every cycle at undivided clock win over the enable
      phase = "R6";
      cyc(2'd2, 1'b1, 8'h0F, 1'b0);
      for (int i = 0; i < 8; i++) cyc(2'd1, 1'b1, 8'hFF, 1'b0);
      idle(2'd1, 2);

      // R5: wrap at undivided clock
      phase = "R5";
      cyc(2'd1, 1'b1, 8'hFC, 1'b0);
      idle(2'd1, 4);
      idle(2'd0, 4);

      // R8: rejected clear values, then the valid one
      phase = "R8";
      cyc(2'd1, 1'b1, 8'h00, 1'b0);
      cyc(2'd2, 1'b1, 8'h0E, 1'b0);
      cyc(2'd0, 1'b1, 8'h00, 1'b0);
      cyc(2'd0, 1'b1, 8'h06, 1'b0);
      cyc(2'd0, 1'b1, 8'h05, 1'b0);
      cyc(2'd0, 1'b1, 8'h03, 1'b0);
      cyc(2'd0, 1'b1, 8'hFF, 1'b0);
      idle(2'd0, 1);
      chk("R8", bus_rdata, 8'h01);
      cyc(2'd0, 1'b1, 8'h04, 1'b0);
      idle(2'd0, 2);
      chk("R8", bus_rdata, 8'h00);

      // R9: no write can set the flag
      phase = "R9";
      cyc(2'd0, 1'b1, 8'h01, 1'b0);
      cyc(2'd0, 1'b1, 8'h07, 1'b0);
      cyc(2'd0, 1'b1, 8'hFD, 1'b0);
      idle(2'd0, 2);
      chk("R9", bus_rdata, 8'h00);

      // R7: reserved bits read as ones, oscillator code selected
      phase = "R7";
      cyc(2'd2, 1'b1, 8'h30, 1'b0);
      idle(2'd2, 2);
      chk("R7", bus_rdata, 8'hF0);

      // R4: oscillator edge reaches the counter on the third edge
      phase = "R4";
      cyc(2'd1, 1'b1, 8'h10, 1'b0);
      idle(2'd1, 4);
      cyc(2'd1, 1'b0, 8'h00, 1'b1);   // input rises after this falling edge
      idle(2'd1, 2);
      chk("R4", bus_rdata, 8'h10);
      idle(2'd1, 1);
      chk("R4", bus_rdata, 8'h11);
      idle(2'd1, 6);
      chk("R4", bus_rdata, 8'h11);    // held high: no further steps
      for (int i = 0; i < 6; i++) begin
         cyc(2'd1, 1'b0, 8'h00, 1'b0);
         cyc(2'd1, 1'b0, 8'h00, 1'b0);
         cyc(2'd1, 1'b0, 8'h00, 1'b1);
         cyc(2'd1, 1'b0, 8'h00, 1'b1);
      end
      idle(2'd1, 4);
      chk("R4", bus_rdata, 8'h17);

      // R3: every divided tap, preloaded near wrap
      phase = "R3";
      for (int k = 0; k < 7; k++) begin
         cyc(2'd2, 1'b1, 8'(8 + k), 1'b0);
         cyc(2'd1, 1'b1, 8'hFE, 1'b0);
         idle(2'd1, 2 * period(3'(k)) + 4);
         idle(2'd0, 1);
         cyc(2'd0, 1'b1, 8'h04, 1'b0);
      end

      // Constrained random traffic
      phase = "";
      for (int i = 0; i < 60000; i++) begin
         logic [1:0] a;
         logic [7:0] d;
         logic we;
         a  = 2'($urandom_range(0, 3));
         we = ($urandom_range(0, 15) == 0);
         d  = 8'($urandom);
         if (a == 2'd0 && $urandom_range(0, 1) == 1) d = 8'h04;
         if (a == 2'd1) d = d | 8'hC0;
         if (a == 2'd2 && $urandom_range(0, 3) != 0) d = {4'h0, 1'b1, 3'($urandom_range(0, 1)) * 3'd7};
         cyc(a, we, d, ($urandom_range(0, 3) == 0) ? ~osc_tick : osc_tick);
      end
      idle(2'd0, 2);
      finish_run();
   end

endmodule